// File: doc/BRIEF.md
# Serial Sync-Marker Frame Aligner

This block sits after a hard-decision convolutional decoder. It receives a serial bit stream, one bit for each cycle in which the bit strobe is high, and regroups it into bytes for a downstream block decoder. A continuously running comparator watches the 32 most recently accepted bits for a fixed attached sync marker. The marker value is a parameter and defaults to 32'h1ACFFC1D.

When the marker is seen, the block re-aligns its byte boundary to the marker. It emits the marker's final byte at once, raises a one-cycle hit flag with that byte, and starts a new byte with the next accepted bit. As a result, every following byte begins on a marker byte boundary. The earliest marker bit therefore lands in a byte MSB, and a controller can use the hit flag to confirm frame lock.

Top module: `frame_aligner`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, byte_vld and sync_hit are 0 and byte_out is 0.
- R2: Each group of eight accepted bits (cycles with bit_vld high) since the last boundary is emitted as one byte. The earliest bit of the group is byte_out[7] and the latest is byte_out[0]. byte_vld pulses for one cycle on the clock edge that accepts the eighth bit.
- R3: A cycle with bit_vld low accepts no bit and changes no state. In the following cycle byte_vld and sync_hit are 0.
- R4: A detection occurs on the edge that accepts a bit that makes the last 32 accepted bits equal MARKER. The earliest of those bits is compared with MARKER[31] and the latest with MARKER[0]. Detection is evaluated on every accepted bit, including bits that overlap a previous marker.
- R5: On a detection, byte_vld and sync_hit are both 1 for exactly that one cycle, and byte_out equals MARKER[7:0]. This holds whatever the current bit count is.
- R6: A detection sets the boundary, so the next eight accepted bits form the next byte. The first bit after a marker is the MSB of a byte.
- R7: sync_hit is never 1 while byte_vld is 0.
- R8: No detection occurs until at least 32 bits have been accepted since reset, even if the zero-filled window matches MARKER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_in | input | 1 | Serial hard-decision bit |
| bit_vld | input | 1 | bit_in is accepted on this edge when high |
| byte_out | output | BYTE_W | Packed byte, MSB is the earliest bit |
| byte_vld | output | 1 | One-cycle strobe marking byte_out as valid |
| sync_hit | output | 1 | One-cycle flag: the byte on byte_out is the marker's last byte |

## Verification
Every result is registered exactly once. A bit accepted on one edge therefore shows up on the byte strobe, the hit flag and the byte bus one cycle later, and these are visible after that edge. The bench drives inputs on the falling edge and updates a behavioural model, built from a queue of accepted bits, in the same step. On the next falling edge it compares all three outputs against that model, so each check lands on the one cycle in which its result is due. Scenarios cover the partial-fill window after reset, markers at every bit offset, gapped strobes, overlapping markers and a mid-stream reset. A final count of hits confirms that no detection was missed or added.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam logic [31:0] FA_SYNC_DEFAULT = 32'h1ACFFC1D;

  typedef struct packed {
    logic vld;
    logic hit;
  } fa_strobe_t;
endpackage

// File: rtl/fa_shift_window.sv
module fa_shift_window #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bit_vld,
  output logic [W-1:0] win_nxt,
  output logic         full_nxt
);
  localparam int FILL_W = $clog2(W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(W);

  logic [W-1:0]      win_q;
  logic [FILL_W-1:0] fill_q, fill_d;

  always_comb begin
    win_nxt = win_q;
    fill_d  = fill_q;
    if (bit_vld) begin
      win_nxt = {win_q[W-2:0], bit_in};
      if (fill_q != FILL_MAX) fill_d = fill_q + 1'b1;
    end
    full_nxt = (fill_d == FILL_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      win_q  <= win_nxt;
      fill_q <= fill_d;
    end
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_MAX); // R8
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(win_q)); // R3
endmodule

// File: rtl/fa_marker_cmp.sv
module fa_marker_cmp #(
  parameter int         W      = 32,
  parameter logic [W-1:0] MARKER = fa_pkg::FA_SYNC_DEFAULT
) (
  input  logic [W-1:0] win_nxt,
  input  logic         full_nxt,
  input  logic         bit_vld,
  output logic         hit
);
  logic [W-1:0] eq_bits;

  for (genvar i = 0; i < W; i++) begin : g_eq
    assign eq_bits[i] = ~(win_nxt[i] ^ MARKER[i]);
  end

  assign hit = bit_vld && full_nxt && (&eq_bits);
endmodule

// File: rtl/fa_byte_packer.sv
module fa_byte_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              hit,
  input  logic [BYTE_W-1:0] last_bits,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              sync_hit
);
  import fa_pkg::*;

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  fa_strobe_t        stb_q, stb_d;

  always_comb begin
    cnt_d  = cnt_q;
    byte_d = byte_q;
    stb_d  = '0;
    if (bit_vld) begin
      if (hit) begin
        cnt_d     = '0;
        byte_d    = last_bits;
        stb_d.vld = 1'b1;
        stb_d.hit = 1'b1;
      end else if (cnt_q == CNT_LAST) begin
        cnt_d     = '0;
        byte_d    = last_bits;
        stb_d.vld = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      byte_q <= '0;
      stb_q  <= '0;
    end else begin
      stb_q <= stb_d;
      if (bit_vld) begin
        cnt_q  <= cnt_d;
        byte_q <= byte_d;
      end
    end
  end

  assign byte_out = byte_q;
  assign byte_vld = stb_q.vld;
  assign sync_hit = stb_q.hit;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> (!byte_vld && !sync_hit)); // R3
  AST_HIT_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |-> byte_vld); // R7
  AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |-> (cnt_q == '0)); // R6
  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !bit_vld) |=> !sync_hit); // R5
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int                   MARKER_W = 32,
  parameter logic [MARKER_W-1:0] MARKER   = fa_pkg::FA_SYNC_DEFAULT,
  parameter int                   BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              sync_hit
);
  logic [MARKER_W-1:0] win_nxt;
  logic                full_nxt;
  logic                hit;

  fa_shift_window #(.W(MARKER_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .bit_vld  (bit_vld),
    .win_nxt  (win_nxt),
    .full_nxt (full_nxt)
  );

  fa_marker_cmp #(.W(MARKER_W), .MARKER(MARKER)) u_cmp (
    .win_nxt  (win_nxt),
    .full_nxt (full_nxt),
    .bit_vld  (bit_vld),
    .hit      (hit)
  );

  fa_byte_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .hit       (hit),
    .last_bits (win_nxt[BYTE_W-1:0]),
    .byte_out  (byte_out),
    .byte_vld  (byte_vld),
    .sync_hit  (sync_hit)
  );

  AST_HIT_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |-> (byte_out == MARKER[BYTE_W-1:0])); // R5
  AST_VLD_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(bit_vld)); // R2
endmodule

// File: tb/frame_aligner_tb.sv
`timescale 1ns/1ps
module frame_aligner_tb;
  localparam logic [31:0] MK = 32'h1ACFFC1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic [7:0] byte_out;
  logic byte_vld, sync_hit;

  always #2.5 clk = ~clk;

  frame_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .byte_out(byte_out), .byte_vld(byte_vld), .sync_hit(sync_hit)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R2";

  bit   hist[$];
  int   since_bnd = 0;
  logic exp_vld = 1'b0, exp_hit = 1'b0;
  logic [7:0] exp_byte = 8'h00;
  int   exp_hits = 0, seen_hits = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    since_bnd = 0;
    exp_vld = 1'b0; exp_hit = 1'b0; exp_byte = 8'h00;
  endtask

  function automatic logic [31:0] last_n(input int n);
    logic [31:0] v = '0;
    for (int i = hist.size() - n; i < hist.size(); i++) v = {v[30:0], hist[i]};
    return v;
  endfunction

  task automatic compare();
    chk({tag, " byte_vld"}, byte_vld, exp_vld);
    chk({tag, " sync_hit"}, sync_hit, exp_hit);
    if (exp_vld) chk({tag, " byte_out"}, byte_out, exp_byte);
    if (sync_hit && !byte_vld) chk("R7 hit without byte", 1, 0);
    if (sync_hit) seen_hits++;
  endtask

  task automatic step(input logic b, input logic v);
    @(negedge clk);
    compare();
    bit_in = b; bit_vld = v;
    exp_vld = 1'b0; exp_hit = 1'b0;
    if (v) begin
      hist.push_back(b);
      if (hist.size() > 32) void'(hist.pop_front());
      since_bnd++;
      if (hist.size() == 32 && last_n(32) == MK) begin
        exp_vld = 1'b1; exp_hit = 1'b1; exp_byte = MK[7:0];
        since_bnd = 0; exp_hits++;
      end else if (since_bnd == 8) begin
        exp_vld = 1'b1; exp_byte = last_n(8)[7:0];
        since_bnd = 0;
      end
    end
  endtask

  task automatic send_marker(input int gap_pct);
    for (int i = 31; i >= 0; i--) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) step($urandom, 1'b0);
      step(MK[i], 1'b1);
    end
  endtask

  task automatic send_rand(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) step($urandom, 1'b0);
      step($urandom, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(7));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 byte_vld in reset", byte_vld, 0);
    chk("R1 sync_hit in reset", sync_hit, 0);
    chk("R1 byte_out in reset", byte_out, 0);
    rst_n = 1'b1;
    tag = "R1";
    step(1'b0, 1'b0);

    tag = "R8";
    for (int i = 28; i >= 0; i--) step(MK[i], 1'b1);
    step(1'b0, 1'b0);
    chk("R8 no hit on partial fill", seen_hits, 0);

    tag = "R2";
    send_rand(40, 0);

    for (int off = 0; off < 8; off++) begin
      tag = "R4";
      send_rand(off + 5, 0);
      send_marker(0);
      tag = "R6";
      send_rand(24, 0);
    end

    tag = "R3";
    send_rand(150, 40);
    send_marker(30);
    send_rand(30, 30);
    repeat (4) step(1'b1, 1'b0);

    tag = "R5";
    send_marker(0);
    send_marker(0);
    send_rand(8, 0);

    tag = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b0; bit_vld = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 mid-run reset byte_vld", byte_vld, 0);
    chk("R1 mid-run reset byte_out", byte_out, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    tag = "R8";
    send_rand(5, 0);
    send_marker(0);
    tag = "R2";
    send_rand(16, 0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    chk("R4 total detections", seen_hits, exp_hits);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule